// File: doc/BRIEF.md
# Serial Receive Buffer with DMA Request and Idle Timeout

This block sits on the receive side of a serial port, between a deserializer that delivers whole characters and a consumer that is either a DMA controller or a CPU. Each received character is pushed into a 16-entry first-in first-out store. The oldest character is always presented on the read port, and a read strobe removes it. Two request lines let a DMA controller service the store. The burst request is raised while the fill level is at or above a programmable watermark, and the single request is raised while any character is waiting. A DMA enable gates both lines.

The DMA controller is expected to fetch a fixed burst that is shorter than the watermark, for example 4 characters against a watermark of 8. Characters are therefore left behind after each burst. An idle timer counts bit-period ticks while data waits. If 32 ticks pass with no write and no read, it flags a receive timeout. Software then turns off DMA, drains the leftover characters through the read port, clears the flag and turns DMA back on. No character is left stranded below the watermark.

Top module: `rx_burst_fifo`

## Requirements
- R1: The store holds up to 16 characters in arrival order. `rd_data` shows the oldest character without delay, a read strobe removes it at the clock edge, and `fill_lvl` gives the count (0 to 16).
- R2: `burst_req` is high exactly while `dma_en` is 1, `fill_lvl >= wmark_lvl`, and no DMA clear was sampled at the previous edge.
- R3: `single_req` is high exactly while `dma_en` is 1 and `fill_lvl` is at least 1.
- R4: With data stored, the timeout pending flag rises at the clock edge that samples the 32nd bit tick since the last write or read. After 31 ticks it is still low. It fires once per idle period, and a flag that has been cleared is not raised again without a new write or read. This also holds when a 4-character burst has left data below the watermark.
- R5: While `dma_en` is 0, neither request output is high, whatever the fill level.
- R6: A `dma_clr` pulse sampled at an edge holds `burst_req` low for the following cycle. After that, the request is computed again from the fill level.
- R7: The idle count restarts on every accepted write and every effective read, and it stays at zero while the store is empty.
- R8: `tmo_pending` stays high until `tmo_clr` is sampled high or the store is empty at an edge. `tmo_irq` equals `tmo_pending` with `tmo_mask` = 1 forcing it low, and the mask does not change `tmo_pending`.
- R9: A write while the store holds 16 characters and no read is made discards the character. The write sets `overrun`, which stays 1 until reset, and leaves the contents unchanged.
- R10: A read of an empty store returns 0 on `rd_data` and leaves `fill_lvl` at 0.
- R11: A write and a read in the same cycle on a full store both take effect. `fill_lvl` stays at 16 and the new character becomes the youngest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received character is on `in_data` |
| in_data | input | 8 | Received character |
| bit_tick | input | 1 | One pulse per serial bit period |
| rd_en | input | 1 | Remove the oldest character (DMA or CPU) |
| rd_data | output | 8 | Oldest character, 0 when empty |
| fill_lvl | output | 5 | Number of stored characters |
| overrun | output | 1 | Sticky: a character was dropped on a full store |
| dma_en | input | 1 | Enables both request outputs |
| wmark_lvl | input | 5 | Burst request watermark (8 in normal use) |
| dma_clr | input | 1 | Pulse after each completed burst |
| burst_req | output | 1 | Burst request to the DMA controller |
| single_req | output | 1 | Single request to the DMA controller |
| tmo_mask | input | 1 | 1 masks the timeout interrupt |
| tmo_clr | input | 1 | Write-one-to-clear for the timeout flag |
| tmo_pending | output | 1 | Timeout pending status |
| tmo_irq | output | 1 | Masked timeout interrupt |

## Verification
On every cycle, the assertions check the following: the fill level stays within bounds, a write into a full store with no read is dropped and raises the overrun flag, and an empty read leaves the count at zero. They also check that the requests are silent without DMA enable, that a DMA clear drops the burst request, that the idle count stays at zero while the store is empty, and that a rising timeout flag only follows a full idle count. Only the bench scenarios can show the following: characters leave in arrival order, the burst request tracks every pairing of fill level and watermark, and the timeout fires on exactly the 32nd tick and not the 31st. They also show the restart of the count by writes and reads, and the drain sequence in which a 4-character burst leaves data that only the timeout reports.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   localparam int unsigned RXB_DATA_W    = 8;
   localparam int unsigned RXB_DEPTH     = 16;
   localparam int unsigned RXB_IDLE_BITS = 32;

   // bits needed to index or count n distinct values (at least one)
   function automatic int unsigned rxb_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill,
   output logic              empty,
   output logic              wr_done,
   output logic              rd_done,
   output logic              overrun
);
   localparam int unsigned    PTR_W    = rxb_pkg::rxb_width(DEPTH);
   localparam bit             POW2     = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_inc, rd_ptr_inc;
   logic [CNT_W-1:0]  fill_q;
   logic              overrun_q;
   logic              full;

   assign full    = (fill_q == FULL_LVL);
   assign empty   = (fill_q == '0);
   assign rd_done = rd_req & ~empty;
   assign wr_done = wr_req & (~full | rd_done);

   // pointer advance: natural wrap for power-of-two depths, compare otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_ptr_inc = wr_ptr_q + 1'b1;
         assign rd_ptr_inc = rd_ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_inc = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         assign rd_ptr_inc = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_done) begin
         slot_q[wr_ptr_q] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q  <= '0;
         rd_ptr_q  <= '0;
         fill_q    <= '0;
         overrun_q <= 1'b0;
      end else begin
         if (wr_done) wr_ptr_q <= wr_ptr_inc;
         if (rd_done) rd_ptr_q <= rd_ptr_inc;
         case ({wr_done, rd_done})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
         if (wr_req && !wr_done) overrun_q <= 1'b1;
      end
   end

   assign rd_data = empty ? '0 : slot_q[rd_ptr_q];
   assign fill    = fill_q;
   assign overrun = overrun_q;

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FULL_LVL); // R1

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && full && !rd_req) |=> (fill_q == FULL_LVL && overrun_q)); // R9

   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty && !wr_req) |=> (fill_q == '0)); // R10
endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
   parameter int unsigned IDLE_BITS = 32,
   parameter int unsigned TW        = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic restart,
   input  logic empty,
   input  logic tmo_clr,
   output logic pending
);
   localparam logic [TW-1:0] IDLE_LIMIT = TW'(IDLE_BITS);
   localparam logic [TW-1:0] IDLE_LAST  = TW'(IDLE_BITS - 1);

   logic [TW-1:0] cnt_q;
   logic          pending_q;
   logic          fire;

   assign fire = bit_tick & ~empty & ~restart & (cnt_q == IDLE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (empty || restart) begin
         cnt_q <= '0;
      end else if (bit_tick && cnt_q != IDLE_LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
      end else if (tmo_clr || empty) begin
         pending_q <= 1'b0;
      end else if (fire) begin
         pending_q <= 1'b1;
      end
   end

   assign pending = pending_q;

   AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> (cnt_q == '0)); // R7

   AST_TMO_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending_q) |-> (cnt_q == IDLE_LIMIT)); // R4

   AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_clr |=> !pending_q); // R8
endmodule

// File: rtl/rxb_req_gen.sv
module rxb_req_gen #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_en,
   input  logic             dma_clr,
   input  logic [CNT_W-1:0] fill,
   input  logic [CNT_W-1:0] wmark,
   output logic             burst_req,
   output logic             single_req
);
   logic clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_q <= 1'b0;
      else        clr_q <= dma_clr;
   end

   assign burst_req  = dma_en & ~clr_q & (fill >= wmark);
   assign single_req = dma_en & (fill != '0);

   AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> (!burst_req && !single_req)); // R5

   AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      dma_clr |=> !burst_req); // R6
endmodule

// File: rtl/rx_burst_fifo.sv
module rx_burst_fifo #(
   parameter int unsigned DATA_W    = rxb_pkg::RXB_DATA_W,
   parameter int unsigned DEPTH     = rxb_pkg::RXB_DEPTH,
   parameter int unsigned IDLE_BITS = rxb_pkg::RXB_IDLE_BITS,
   localparam int unsigned CNT_W    = rxb_pkg::rxb_width(DEPTH + 1),
   localparam int unsigned TW       = rxb_pkg::rxb_width(IDLE_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              bit_tick,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill_lvl,
   output logic              overrun,
   input  logic              dma_en,
   input  logic [CNT_W-1:0]  wmark_lvl,
   input  logic              dma_clr,
   output logic              burst_req,
   output logic              single_req,
   input  logic              tmo_mask,
   input  logic              tmo_clr,
   output logic              tmo_pending,
   output logic              tmo_irq
);
   initial begin
      assert (DATA_W >= 1)    else $error("rx_burst_fifo: DATA_W must be at least 1");
      assert (DEPTH >= 2)     else $error("rx_burst_fifo: DEPTH must be at least 2");
      assert (IDLE_BITS >= 2) else $error("rx_burst_fifo: IDLE_BITS must be at least 2");
   end

   logic empty, wr_done, rd_done;

   rxb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (in_valid),
      .wr_data (in_data),
      .rd_req  (rd_en),
      .rd_data (rd_data),
      .fill    (fill_lvl),
      .empty   (empty),
      .wr_done (wr_done),
      .rd_done (rd_done),
      .overrun (overrun)
   );

   rxb_req_gen #(.CNT_W(CNT_W)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .dma_en     (dma_en),
      .dma_clr    (dma_clr),
      .fill       (fill_lvl),
      .wmark      (wmark_lvl),
      .burst_req  (burst_req),
      .single_req (single_req)
   );

   rxb_idle_timer #(.IDLE_BITS(IDLE_BITS), .TW(TW)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .restart  (wr_done | rd_done),
      .empty    (empty),
      .tmo_clr  (tmo_clr),
      .pending  (tmo_pending)
   );

   assign tmo_irq = tmo_pending & ~tmo_mask;
endmodule

// File: tb/sim_rx_burst_fifo.sv
`timescale 1ns/1ps
module sim_rx_burst_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 0, bit_tick = 0, rd_en = 0;
   logic [7:0] in_data = 0;
   logic [7:0] rd_data;
   logic [4:0] fill_lvl;
   logic       overrun;
   logic       dma_en = 0, dma_clr = 0, tmo_mask = 0, tmo_clr = 0;
   logic [4:0] wmark_lvl = 5'd8;
   logic       burst_req, single_req, tmo_pending, tmo_irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] model[$];

   always #2.5 clk = ~clk;

   rx_burst_fifo u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .bit_tick(bit_tick), .rd_en(rd_en), .rd_data(rd_data), .fill_lvl(fill_lvl),
      .overrun(overrun), .dma_en(dma_en), .wmark_lvl(wmark_lvl), .dma_clr(dma_clr),
      .burst_req(burst_req), .single_req(single_req), .tmo_mask(tmo_mask),
      .tmo_clr(tmo_clr), .tmo_pending(tmo_pending), .tmo_irq(tmo_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] d);
      in_valid = 1; in_data = d;
      edge1();
      in_valid = 0;
      if (model.size() < 16) model.push_back(d);
   endtask

   task automatic pop(input string tag);
      chk(tag, rd_data, (model.size() != 0) ? model[0] : 0);
      rd_en = 1;
      edge1();
      rd_en = 0;
      if (model.size() != 0) void'(model.pop_front());
      chk(tag, fill_lvl, model.size());
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1;
         edge1();
         bit_tick = 0;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      edge1();
      // reset state
      chk("R1 reset fill", fill_lvl, 0);
      chk("R10 reset rd_data", rd_data, 0);
      chk("R9 reset overrun", overrun, 0);
      chk("R8 reset pending", tmo_pending, 0);
      chk("R2 reset burst", burst_req, 0);

      // R5: requests silent while disabled
      for (int i = 0; i < 10; i++) push(8'h10 + 8'(i));
      chk("R5 burst off", burst_req, 0);
      chk("R5 single off", single_req, 0);
      chk("R1 fill 10", fill_lvl, 10);
      while (model.size() != 0) pop("R1 order");

      // R2/R3: sweep every fill level against every watermark
      dma_en = 1;
      for (int f = 0; f <= 16; f++) begin
         for (int w = 0; w <= 16; w++) begin
            wmark_lvl = 5'(w);
            #0.5;
            chk($sformatf("R2 burst f=%0d w=%0d", f, w), burst_req, (f >= w) ? 1 : 0);
         end
         chk($sformatf("R3 single f=%0d", f), single_req, (f != 0) ? 1 : 0);
         chk("R1 fill sweep", fill_lvl, f);
         if (f < 16) push(8'h40 + 8'(f));
      end
      wmark_lvl = 5'd8;

      // R9: overrun on full store
      push(8'hEE);
      push(8'hEF);
      chk("R9 fill held", fill_lvl, 16);
      chk("R9 overrun set", overrun, 1);

      // R11: simultaneous read and write on full store
      chk("R11 head", rd_data, model[0]);
      in_valid = 1; in_data = 8'hA5; rd_en = 1;
      edge1();
      in_valid = 0; rd_en = 0;
      void'(model.pop_front()); model.push_back(8'hA5);
      chk("R11 fill stays", fill_lvl, 16);

      // R6: clear pulse drops burst request one cycle
      chk("R6 burst before", burst_req, 1);
      dma_clr = 1;
      edge1();
      dma_clr = 0;
      chk("R6 burst dropped", burst_req, 0);
      edge1();
      chk("R6 burst back", burst_req, 1);

      while (model.size() != 0) pop("R1 drain order");
      chk("R9 overrun sticky", overrun, 1);
      // R10: empty read
      pop("R10 empty read");
      chk("R10 empty data", rd_data, 0);

      // R4: exact 32-tick threshold
      push(8'h77);
      ticks(31);
      chk("R4 31 ticks", tmo_pending, 0);
      ticks(1);
      chk("R4 32 ticks", tmo_pending, 1);
      chk("R8 irq", tmo_irq, 1);
      // R8: mask gates irq only
      tmo_mask = 1; #0.5;
      chk("R8 masked irq", tmo_irq, 0);
      chk("R8 masked pending", tmo_pending, 1);
      tmo_mask = 0; #0.5;
      chk("R8 unmasked irq", tmo_irq, 1);
      tmo_clr = 1;
      edge1();
      tmo_clr = 0;
      chk("R8 cleared", tmo_pending, 0);
      ticks(40);
      chk("R4 no refire", tmo_pending, 0);

      // R7: write restarts the count
      ticks(5);
      push(8'h78);
      ticks(31);
      chk("R7 write restart 31", tmo_pending, 0);
      ticks(1);
      chk("R7 write restart 32", tmo_pending, 1);
      tmo_clr = 1; edge1(); tmo_clr = 0;
      // R7: read restarts the count
      push(8'h79);
      ticks(20);
      pop("R7 read data");
      ticks(31);
      chk("R7 read restart 31", tmo_pending, 0);
      ticks(1);
      chk("R7 read restart 32", tmo_pending, 1);
      // R8: emptying the store clears pending
      while (model.size() != 0) pop("R8 drain");
      edge1();
      chk("R8 empty clears", tmo_pending, 0);
      // R7: idle ticks on empty store do not count
      ticks(40);
      chk("R7 empty idle", tmo_pending, 0);
      push(8'h7A);
      ticks(31);
      chk("R7 fresh count 31", tmo_pending, 0);
      ticks(1);
      chk("R7 fresh count 32", tmo_pending, 1);
      pop("R7 cleanup");
      edge1();

      // R4: 4-character burst leaves data below watermark, timeout reports it
      for (int i = 0; i < 8; i++) push(8'h90 + 8'(i));
      chk("R4 burst raised", burst_req, 1);
      for (int i = 0; i < 4; i++) pop("R4 burst read");
      chk("R4 burst low after 4", burst_req, 0);
      chk("R4 single still", single_req, 1);
      ticks(32);
      chk("R4 leftover timeout", tmo_pending, 1);
      dma_en = 0; #0.5;
      chk("R5 disabled single", single_req, 0);
      while (model.size() != 0) pop("R4 cpu drain");
      edge1();
      chk("R8 drained pending", tmo_pending, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule